// File: doc/BRIEF.md
# Receive Statistics Counter Set

This block holds the receive-side statistics of an Ethernet MAC. The receive status logic sends it single-cycle event pulses: a runt frame addressed to this station, a collision seen on the wire, a frame received without error, an address-matched frame that completed during a FIFO overflow, the last byte of a frame entering the receive FIFO, and the last byte of a frame leaving it toward the host. From these it keeps four counters that the host reads directly from plain output buses.

The runt and collision counters measure trouble since the most recent good frame, so a good-frame pulse resets both. The missed-frame counter only advances while the overflow indication is high, and it is emptied when the host reads it. The frame tally tracks how many complete frames currently sit in the receive FIFO; while the FIFO is in overflow, incoming frame completions are dropped and so do not add to the tally. A synchronous clear input wipes the three statistic counters without touching the frame tally. All counters stop at their maximum rather than wrapping.

Top module: `rx_stat_counters`

## Requirements
- R1: `runt_cnt` (8 bits) rises by one on the clock edge that samples `ev_runt` high, and stays at 255 once it gets there.
- R2: `coll_cnt` (8 bits) rises by one on the clock edge that samples `ev_coll` high, and stays at 255 once it gets there.
- R3: A sampled `ev_good` sets both `runt_cnt` and `coll_cnt` to 0 on that edge, even when `ev_runt` or `ev_coll` is high in the same cycle.
- R4: `miss_cnt` (8 bits) rises by one on an edge where `ev_missed` and `ovfl_active` are both high; `ev_missed` with `ovfl_active` low leaves it unchanged.
- R5: `miss_cnt` stays at 255 once it gets there.
- R6: A sampled `miss_rd` sets `miss_cnt` to 0; if a counted missed frame (`ev_missed` with `ovfl_active`) arrives in the same cycle, `miss_cnt` becomes 1 instead.
- R7: `fifo_frames` (4 bits) rises by one on `ev_wr_last`, falls by one on `ev_rd_last`, and holds when both are counted in the same cycle.
- R8: `fifo_frames` stays at 15 on a lone write event and stays at 0 on a lone read event.
- R9: While `ovfl_active` is high, `ev_wr_last` has no effect on `fifo_frames`; `ev_rd_last` still decrements it.
- R10: A sampled `clr_all` sets `runt_cnt`, `coll_cnt` and `miss_cnt` to 0 regardless of any other event in that cycle, and leaves `fifo_frames` to follow R7 to R9.
- R11: After reset (`rst_n` low) all four counters read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_all | input | 1 | Clear the three statistic counters |
| ev_runt | input | 1 | Runt frame addressed to this station |
| ev_coll | input | 1 | Collision seen on the network |
| ev_good | input | 1 | Frame received without error |
| ev_missed | input | 1 | Address-matched frame completed without collision |
| ovfl_active | input | 1 | Receive FIFO is in overflow |
| ev_wr_last | input | 1 | Last byte of a frame written into the receive FIFO |
| ev_rd_last | input | 1 | Last byte of a frame read by the host |
| miss_rd | input | 1 | Host reads the missed-frame counter (clear on read) |
| runt_cnt | output | 8 | Runt frames since the last good frame |
| coll_cnt | output | 8 | Collisions since the last good frame |
| miss_cnt | output | 8 | Frames missed during overflow |
| fifo_frames | output | 4 | Complete frames held in the receive FIFO |

## Verification
The properties assume every event input is a one-cycle-wide, edge-sampled level that may coincide with any other, and that reset is held long enough for one rising edge. They assume nothing about ordering between write and read completions, so the stimulus drives single events, pairs that collide in one cycle (good with runt, read with a counted miss, write with read, clear with increments) and long runs that push each counter into its ceiling or floor. Overflow is raised and lowered mid-sequence so that both gated paths see the signal in each state.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

   // Action taken by an up/down tally in one cycle.
   typedef enum logic [1:0] {
      TALLY_HOLD = 2'd0,
      TALLY_UP   = 2'd1,
      TALLY_DOWN = 2'd2
   } tally_op_e;

   // Resolve a pair of increment / decrement requests into one action.
   function automatic tally_op_e tally_decode(input logic up, input logic down);
      if (up && !down)      return TALLY_UP;
      else if (down && !up) return TALLY_DOWN;
      else                  return TALLY_HOLD;
   endfunction

endpackage

// File: rtl/rxs_sat_counter.sv
module rxs_sat_counter #(
   parameter int W        = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_hard,
   input  logic         clr_soft,
   input  logic         inc,
   output logic [W-1:0] q
);

   localparam logic [W-1:0] MAXV = {W{1'b1}};
   localparam logic [W-1:0] ONE  = W'(1);

   logic [W-1:0] bumped;

   generate
      if (W < 2) begin : g_bad_width
         $error("rxs_sat_counter: W must be at least 2");
      end
      if (SATURATE) begin : g_sat
         assign bumped = (q == MAXV) ? q : q + ONE;
      end else begin : g_wrap
         assign bumped = q + ONE;
      end
   endgenerate

   // Hard clear beats everything; soft clear keeps a same-cycle increment.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= '0;
      end else if (clr_hard) begin
         q <= '0;
      end else if (clr_soft) begin
         q <= inc ? ONE : '0;
      end else if (inc) begin
         q <= bumped;
      end
   end

endmodule

// File: rtl/rxs_frame_tally.sv
module rxs_frame_tally
   import rxs_pkg::*;
#(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         up,
   input  logic         down,
   output logic [W-1:0] q
);

   localparam logic [W-1:0] MAXV = {W{1'b1}};
   localparam logic [W-1:0] ONE  = W'(1);

   generate
      if (W < 1) begin : g_bad_width
         $error("rxs_frame_tally: W must be at least 1");
      end
   endgenerate

   tally_op_e op;

   always_comb begin
      op = tally_decode(up, down);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= '0;
      end else begin
         unique case (op)
            TALLY_UP:   if (q != MAXV) q <= q + ONE;
            TALLY_DOWN: if (q != '0)   q <= q - ONE;
            default:    q <= q;
         endcase
      end
   end

endmodule

// File: rtl/rx_stat_counters.sv
module rx_stat_counters #(
   parameter int STAT_W  = 8,
   parameter int FRAME_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr_all,
   input  logic               ev_runt,
   input  logic               ev_coll,
   input  logic               ev_good,
   input  logic               ev_missed,
   input  logic               ovfl_active,
   input  logic               ev_wr_last,
   input  logic               ev_rd_last,
   input  logic               miss_rd,
   output logic [STAT_W-1:0]  runt_cnt,
   output logic [STAT_W-1:0]  coll_cnt,
   output logic [STAT_W-1:0]  miss_cnt,
   output logic [FRAME_W-1:0] fifo_frames
);

   localparam int N_SINCE_GOOD = 2;

   // Event qualification at the block edge.
   logic since_good_clr;
   logic miss_counted;
   logic wr_counted;

   assign since_good_clr = clr_all | ev_good;
   assign miss_counted   = ev_missed & ovfl_active;
   assign wr_counted     = ev_wr_last & ~ovfl_active;

   // Counters reset by a good frame: runt (0) and collision (1).
   logic [N_SINCE_GOOD-1:0]  sg_inc;
   logic [STAT_W-1:0]        sg_q [N_SINCE_GOOD];

   assign sg_inc = {ev_coll, ev_runt};

   generate
      for (genvar i = 0; i < N_SINCE_GOOD; i++) begin : g_since_good
         rxs_sat_counter #(.W(STAT_W), .SATURATE(1'b1)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr_hard (since_good_clr),
            .clr_soft (1'b0),
            .inc      (sg_inc[i]),
            .q        (sg_q[i])
         );
      end
   endgenerate

   assign runt_cnt = sg_q[0];
   assign coll_cnt = sg_q[1];

   rxs_sat_counter #(.W(STAT_W), .SATURATE(1'b1)) u_miss (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_hard (clr_all),
      .clr_soft (miss_rd),
      .inc      (miss_counted),
      .q        (miss_cnt)
   );

   rxs_frame_tally #(.W(FRAME_W)) u_frames (
      .clk   (clk),
      .rst_n (rst_n),
      .up    (wr_counted),
      .down  (ev_rd_last),
      .q     (fifo_frames)
   );

endmodule

// File: rtl/rx_stat_counters_chk.sv
module rx_stat_counters_chk #(
   parameter int STAT_W  = 8,
   parameter int FRAME_W = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               clr_all,
   input logic               ev_runt,
   input logic               ev_coll,
   input logic               ev_good,
   input logic               ev_missed,
   input logic               ovfl_active,
   input logic               ev_wr_last,
   input logic               ev_rd_last,
   input logic               miss_rd,
   input logic [STAT_W-1:0]  runt_cnt,
   input logic [STAT_W-1:0]  coll_cnt,
   input logic [STAT_W-1:0]  miss_cnt,
   input logic [FRAME_W-1:0] fifo_frames
);

   localparam logic [STAT_W-1:0]  SMAX = {STAT_W{1'b1}};
   localparam logic [FRAME_W-1:0] FMAX = {FRAME_W{1'b1}};

   // R1
   runt_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (runt_cnt == SMAX && !ev_good && !clr_all) |=> runt_cnt == SMAX);

   // R2
   coll_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (coll_cnt == SMAX && !ev_good && !clr_all) |=> coll_cnt == SMAX);

   // R3
   good_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_good |=> (runt_cnt == '0 && coll_cnt == '0));

   // R4
   miss_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ovfl_active && !miss_rd && !clr_all) |=> $stable(miss_cnt));

   // R6
   miss_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_rd && !clr_all && !(ev_missed && ovfl_active)) |=> miss_cnt == '0);

   // R7
   frames_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_wr_last && ev_rd_last && !ovfl_active) |=> $stable(fifo_frames));

   // R8
   frames_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_frames == FMAX && !ev_rd_last) |=> fifo_frames == FMAX);

   // R9
   frames_ovfl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovfl_active && !ev_rd_last) |=> $stable(fifo_frames));

   // R10
   clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_all |=> (runt_cnt == '0 && coll_cnt == '0 && miss_cnt == '0));

endmodule

bind rx_stat_counters rx_stat_counters_chk #(.STAT_W(STAT_W), .FRAME_W(FRAME_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .clr_all     (clr_all),
   .ev_runt     (ev_runt),
   .ev_coll     (ev_coll),
   .ev_good     (ev_good),
   .ev_missed   (ev_missed),
   .ovfl_active (ovfl_active),
   .ev_wr_last  (ev_wr_last),
   .ev_rd_last  (ev_rd_last),
   .miss_rd     (miss_rd),
   .runt_cnt    (runt_cnt),
   .coll_cnt    (coll_cnt),
   .miss_cnt    (miss_cnt),
   .fifo_frames (fifo_frames)
);

// File: tb/rx_stat_counters_tb.sv
module rx_stat_counters_tb;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic clr_all = 1'b0, ev_runt = 1'b0, ev_coll = 1'b0, ev_good = 1'b0;
   logic ev_missed = 1'b0, ovfl_active = 1'b0, ev_wr_last = 1'b0;
   logic ev_rd_last = 1'b0, miss_rd = 1'b0;
   logic [7:0] runt_cnt, coll_cnt, miss_cnt;
   logic [3:0] fifo_frames;

   always #5 clk = ~clk;

   rx_stat_counters u_dut (
      .clk(clk), .rst_n(rst_n), .clr_all(clr_all), .ev_runt(ev_runt),
      .ev_coll(ev_coll), .ev_good(ev_good), .ev_missed(ev_missed),
      .ovfl_active(ovfl_active), .ev_wr_last(ev_wr_last),
      .ev_rd_last(ev_rd_last), .miss_rd(miss_rd), .runt_cnt(runt_cnt),
      .coll_cnt(coll_cnt), .miss_cnt(miss_cnt), .fifo_frames(fifo_frames)
   );

   // Event bit positions for the driver task.
   localparam int E_RUNT = 0, E_COLL = 1, E_GOOD = 2, E_MISS = 3, E_OVFL = 4;
   localparam int E_WR = 5, E_RD = 6, E_MRD = 7, E_CLR = 8;

   typedef struct {
      int    r, c, m, f;
      string tag;
   } exp_t;

   exp_t q_exp[$];
   int   checks = 0;
   int   errors = 0;
   bit   finished = 1'b0;

   // Reference model state.
   int mr = 0, mc = 0, mm = 0, mf = 0;

   task automatic step(input logic [8:0] ev, input string tag);
      bit wr_eff, mis_eff;
      exp_t e;
      @(negedge clk);
      ev_runt     = ev[E_RUNT];
      ev_coll     = ev[E_COLL];
      ev_good     = ev[E_GOOD];
      ev_missed   = ev[E_MISS];
      ovfl_active = ev[E_OVFL];
      ev_wr_last  = ev[E_WR];
      ev_rd_last  = ev[E_RD];
      miss_rd     = ev[E_MRD];
      clr_all     = ev[E_CLR];
      mis_eff = ev[E_MISS] && ev[E_OVFL];
      wr_eff  = ev[E_WR] && !ev[E_OVFL];
      if (ev[E_CLR]) begin
         mr = 0; mc = 0; mm = 0;
      end else begin
         if (ev[E_GOOD]) begin
            mr = 0; mc = 0;
         end else begin
            if (ev[E_RUNT] && mr < 255) mr++;
            if (ev[E_COLL] && mc < 255) mc++;
         end
         if (ev[E_MRD])             mm = mis_eff ? 1 : 0;
         else if (mis_eff && mm < 255) mm++;
      end
      if (wr_eff && !ev[E_RD]) begin
         if (mf < 15) mf++;
      end else if (ev[E_RD] && !wr_eff) begin
         if (mf > 0) mf--;
      end
      e.r = mr; e.c = mc; e.m = mm; e.f = mf; e.tag = tag;
      q_exp.push_back(e);
   endtask

   function automatic logic [8:0] bitv(input int pos);
      logic [8:0] v;
      v = '0;
      v[pos] = 1'b1;
      return v;
   endfunction

   // Monitor: compare after each rising edge.
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (q_exp.size() > 0) begin
            exp_t e;
            e = q_exp.pop_front();
            checks++;
            if (int'(runt_cnt) != e.r || int'(coll_cnt) != e.c ||
                int'(miss_cnt) != e.m || int'(fifo_frames) != e.f) begin
               errors++;
               $display("FAIL %s: act runt=%0d coll=%0d miss=%0d frames=%0d exp runt=%0d coll=%0d miss=%0d frames=%0d",
                        e.tag, runt_cnt, coll_cnt, miss_cnt, fifo_frames,
                        e.r, e.c, e.m, e.f);
            end
         end
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   // Watchdog.
   initial begin
      repeat (50000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: act timeout exp completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      checks++;
      if (runt_cnt != 0 || coll_cnt != 0 || miss_cnt != 0 || fifo_frames != 0) begin
         errors++;
         $display("FAIL R11: act %0d %0d %0d %0d exp 0 0 0 0",
                  runt_cnt, coll_cnt, miss_cnt, fifo_frames);
      end

      // R1 counting and ceiling
      for (int i = 0; i < 3; i++) step(bitv(E_RUNT), "R1 count");
      for (int i = 0; i < 257; i++) step(bitv(E_RUNT), "R1 ceiling");
      // R2 counting and ceiling
      for (int i = 0; i < 258; i++) step(bitv(E_COLL), "R2 ceiling");
      // R3 good wins over same-cycle increments
      step(bitv(E_GOOD) | bitv(E_RUNT) | bitv(E_COLL), "R3 good wins");
      step(bitv(E_RUNT) | bitv(E_COLL), "R3 restart");
      step(bitv(E_GOOD), "R3 good alone");
      // R4 missed without overflow ignored, with overflow counted
      step(bitv(E_MISS), "R4 no overflow");
      step(bitv(E_OVFL), "R4 overflow only");
      step(bitv(E_MISS) | bitv(E_OVFL), "R4 counted");
      // R5 ceiling
      for (int i = 0; i < 258; i++) step(bitv(E_MISS) | bitv(E_OVFL), "R5 ceiling");
      // R6 read clear, and read with counted miss
      step(bitv(E_MRD), "R6 read clear");
      step(bitv(E_MISS) | bitv(E_OVFL), "R6 refill");
      step(bitv(E_MISS) | bitv(E_OVFL) | bitv(E_MRD), "R6 read plus miss");
      step(bitv(E_MISS) | bitv(E_MRD), "R6 read plus ungated miss");
      // R7 tally
      for (int i = 0; i < 3; i++) step(bitv(E_WR), "R7 write");
      step(bitv(E_RD), "R7 read");
      step(bitv(E_WR) | bitv(E_RD), "R7 both");
      // R8 ceiling and floor
      for (int i = 0; i < 18; i++) step(bitv(E_WR), "R8 ceiling");
      step(bitv(E_WR) | bitv(E_RD), "R8 both at ceiling");
      for (int i = 0; i < 18; i++) step(bitv(E_RD), "R8 floor");
      step(bitv(E_WR) | bitv(E_RD), "R8 both at floor");
      // R9 writes ignored during overflow, reads still count
      step(bitv(E_WR) | bitv(E_OVFL), "R9 write in overflow");
      step(bitv(E_WR), "R9 write after overflow");
      step(bitv(E_WR), "R9 write again");
      step(bitv(E_WR) | bitv(E_RD) | bitv(E_OVFL), "R9 read in overflow");
      // R10 clear beats increments, tally untouched
      step(bitv(E_RUNT) | bitv(E_COLL), "R10 setup");
      step(bitv(E_MISS) | bitv(E_OVFL), "R10 setup miss");
      step(bitv(E_CLR) | bitv(E_RUNT) | bitv(E_COLL) | bitv(E_MISS) |
           bitv(E_OVFL) | bitv(E_MRD) | bitv(E_WR), "R10 clear wins");
      step(bitv(E_CLR) | bitv(E_WR), "R10 tally moves");
      step('0, "R10 idle");
      step('0, "idle");
      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule